// File: doc/BRIEF.md
# Ethernet MAC Control Register File

This block is the software-visible register file of a 10/100 Ethernet MAC. A host reaches it over a plain 16-bit register bus: a 12-bit byte offset, a write strobe with write data, and a read strobe whose data comes back on `reg_rdata` one clock later and stays there until the next read. The block holds the configuration values the datapath uses, including interface control, transmit and receive configuration, FIFO enables and sizes, the transmit threshold, the backoff seed, the station address and the multicast hash table. These values are driven out on dedicated ports.

The MAC reports activity to the block on event inputs. A status bus sets sticky status bits. A peak-attempt report records the largest retry count seen. A bundle of increment strobes advances the collision and receive-error statistics. An event mask gates status bits onto a single interrupt line. The mask resets to all ones, and a mask bit of 1 blocks its status bit. Two reads have side effects: reading the status register and reading the peak-attempt register each return the value and clear it in the same access. Writing 1 to the transmit reset register gives a one-cycle reset pulse to the transmitter, and the bit then reads back as 0.

Top module: `emac_csr_block`

## Requirements
- R1: Synchronous active-high `rst` sets the event mask to 0xFFFF and sets status, peak attempts, all counters, all configuration storage and `reg_rdata` to 0. After reset, `irq` and `tx_soft_rst` are 0.
- R2: When `reg_rd` is high at a clock edge, `reg_rdata` takes the value of the register at `reg_addr` after that edge and holds it until the next read. A read from an unmapped offset (for example 0x180 or 0x7F0) returns 0. A write to an unmapped offset changes nothing.
- R3: A 1 on bit i of `ev_status` at a clock edge sets status bit i. A read at 0x200 returns the status and clears it. An event that arrives in the same cycle as the read is kept for the next read.
- R4: `irq` is 1 exactly when some status bit is 1 and its bit in the event mask (offset 0x210, read/write) is 0.
- R5: The 8-bit peak-attempt register at 0x4E0 takes `peak_val` on `peak_upd` only when `peak_val` is larger than the value it holds. A read returns the value and clears it. Writes to 0x4E0 are ignored.
- R6: The transmit FIFO control at 0x100 and the receive FIFO control at 0x120 keep written bits 8:0. Bit 0 is the enable, and bits 8:1 are a code N that gives a size of (N+1)*128 bytes on `tx_fifo_bytes`/`rx_fifo_bytes`. Reads return bits 8:0 and 0 above them.
- R7: Each of the nine statistics counters adds one when its `cnt_inc` bit is high and stops at its all-ones value. The bits and offsets are: bit0 normal collisions 0x500, bit1 network collisions 0x510, bit2 excessive collisions 0x520, bit3 late collisions 0x530, bit4 received frames 0x690 (all 16 bits wide), bit5 length errors 0x6A0, bit6 alignment errors 0x6B0, bit7 FCS errors 0x6C0, bit8 code violations 0x6E0 (8 bits wide).
- R8: A write to a counter loads the low bits of the written data that fit its width. A write takes priority over an increment in the same cycle.
- R9: The station address words are at 0x680 (`station_addr[15:0]`), 0x670 (`[31:16]`) and 0x660 (`[47:32]`). The hash words are at 0x700 to 0x730, with the word index taken from offset bits 5:4 and driven on `hash_tab[16*i+15:16*i]`. All of these can be read back.
- R10: A write to 0x420 with data bit 0 set raises `tx_soft_rst` for exactly one cycle, after which the register reads 0. A write with bit 0 clear gives no pulse.
- R11: Interface control 0x000, TX config 0x430, RX config 0x630 and seed 0x540 are 16-bit read/write. The TX threshold at 0x110 keeps 8 bits. The chip ID at 0x170 reads the `CHIP_ID` parameter. Writes to 0x170 and 0x200 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 16 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Read data, valid after the read edge |
| ev_status | input | 16 | Status bit set pulses |
| peak_upd | input | 1 | Peak attempt report strobe |
| peak_val | input | 8 | Reported attempt count |
| cnt_inc | input | 9 | Counter increment strobes |
| irq | output | 1 | Interrupt request |
| tx_soft_rst | output | 1 | One-cycle transmitter reset |
| xif_ctrl | output | 16 | Interface control value |
| tx_cfg | output | 16 | Transmit configuration |
| rx_cfg | output | 16 | Receive configuration |
| tx_thresh | output | 8 | Transmit FIFO threshold |
| rng_seed | output | 16 | Backoff seed |
| tx_fifo_en | output | 1 | Transmit FIFO enable |
| tx_fifo_bytes | output | 16 | Transmit FIFO size in bytes |
| rx_fifo_en | output | 1 | Receive FIFO enable |
| rx_fifo_bytes | output | 16 | Receive FIFO size in bytes |
| station_addr | output | 48 | Station address |
| hash_tab | output | 64 | Multicast hash table |

## Verification
The statistics counters are tested with one strobe repeated, with two strobes in the same cycle, and with a count preloaded one step below its limit. Together these tell apart independent counting, mixed-up strobe bits, and wrap-around in place of saturation. The status and peak registers are read twice after events, which separates clear-on-read from plain storage. A read in the same cycle as a new event shows whether the clear wipes the new event. Writes to FIFO controls with high bits set, to narrow counters with wide data, to read-only registers and to unmapped offsets each produce a readback that would differ if masking or decoding were wrong.

// File: rtl/emac_csr_pkg.sv
`timescale 1ns/1ps
package emac_csr_pkg;
    localparam int DW    = 16;
    localparam int AW    = 12;
    localparam int NCNT  = 9;
    localparam int NWIDE = 5;
    localparam int NADDR = 3;
    localparam int NHASH = 4;
    localparam int PKW   = 8;

    typedef enum logic [3:0] {
        RK_NONE, RK_XIF, RK_TXF, RK_TXTH, RK_RXF, RK_ID, RK_STAT, RK_MASK,
        RK_TXRST, RK_TXCFG, RK_PEAK, RK_CNT, RK_SEED, RK_RXCFG, RK_STA, RK_HASH
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [3:0] idx;
    } reg_sel_t;

    function automatic int cnt_width(input int i);
        return (i < NWIDE) ? 16 : 8;
    endfunction

    function automatic logic [DW-1:0] fifo_bytes(input logic [7:0] code);
        return ({8'd0, code} + 16'd1) << 7;
    endfunction

    function automatic reg_sel_t decode(input logic [AW-1:0] a);
        reg_sel_t s;
        s.kind = RK_NONE;
        s.idx  = 4'd0;
        case (a)
            12'h000: s.kind = RK_XIF;
            12'h100: s.kind = RK_TXF;
            12'h110: s.kind = RK_TXTH;
            12'h120: s.kind = RK_RXF;
            12'h170: s.kind = RK_ID;
            12'h200: s.kind = RK_STAT;
            12'h210: s.kind = RK_MASK;
            12'h420: s.kind = RK_TXRST;
            12'h430: s.kind = RK_TXCFG;
            12'h4E0: s.kind = RK_PEAK;
            12'h500, 12'h510, 12'h520, 12'h530: begin
                s.kind = RK_CNT; s.idx = {2'b00, a[5:4]};
            end
            12'h540: s.kind = RK_SEED;
            12'h630: s.kind = RK_RXCFG;
            12'h660, 12'h670, 12'h680: begin
                s.kind = RK_STA; s.idx = 4'd8 - a[7:4];
            end
            12'h690: begin s.kind = RK_CNT; s.idx = 4'd4; end
            12'h6A0: begin s.kind = RK_CNT; s.idx = 4'd5; end
            12'h6B0: begin s.kind = RK_CNT; s.idx = 4'd6; end
            12'h6C0: begin s.kind = RK_CNT; s.idx = 4'd7; end
            12'h6E0: begin s.kind = RK_CNT; s.idx = 4'd8; end
            12'h700, 12'h710, 12'h720, 12'h730: begin
                s.kind = RK_HASH; s.idx = {2'b00, a[5:4]};
            end
            default: s.kind = RK_NONE;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/emac_sat_ctr.sv
`timescale 1ns/1ps
module emac_sat_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst)                      cnt <= '0;
        else if (wr_en)               cnt <= wr_val;
        else if (inc && cnt != TOP)   cnt <= cnt + 1'b1;
    end

    assert_sat_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (inc && !wr_en && cnt == TOP) |=> cnt == TOP);
    assert_step_one_R7: assert property (@(posedge clk) disable iff (rst)
        (inc && !wr_en && cnt != TOP) |=> cnt == $past(cnt) + 1'b1);
    assert_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> cnt == $past(wr_val));
endmodule

// File: rtl/emac_evt_unit.sv
`timescale 1ns/1ps
module emac_evt_unit
    import emac_csr_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [DW-1:0]  ev_set,
    input  logic           stat_rd,
    input  logic           mask_wr,
    input  logic [DW-1:0]  mask_wdata,
    input  logic           peak_upd,
    input  logic [PKW-1:0] peak_val,
    input  logic           peak_rd,
    output logic [DW-1:0]  stat,
    output logic [DW-1:0]  mask,
    output logic [PKW-1:0] peak,
    output logic           irq
);
    logic [PKW-1:0] peak_base;

    always_comb begin
        peak_base = peak_rd ? '0 : peak;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            mask <= '1;
            peak <= '0;
        end else begin
            stat <= (stat_rd ? '0 : stat) | ev_set;
            if (mask_wr) mask <= mask_wdata;
            if (peak_upd && peak_val > peak_base) peak <= peak_val;
            else                                  peak <= peak_base;
        end
    end

    assign irq = |(stat & ~mask);

    assert_mask_reset_R1: assert property (@(posedge clk)
        rst |=> (mask == '1 && stat == '0));
    assert_clear_on_read_R3: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && ev_set == '0) |=> stat == '0);
    assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        !stat_rd |=> (stat & $past(stat)) == $past(stat));
    assert_peak_monotone_R5: assert property (@(posedge clk) disable iff (rst)
        !peak_rd |=> peak >= $past(peak));
endmodule

// File: rtl/emac_csr_block.sv
`timescale 1ns/1ps
module emac_csr_block
    import emac_csr_pkg::*;
#(
    parameter logic [15:0] CHIP_ID = 16'h000C
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [11:0] reg_addr,
    input  logic [15:0] reg_wdata,
    input  logic        reg_wr,
    input  logic        reg_rd,
    output logic [15:0] reg_rdata,
    input  logic [15:0] ev_status,
    input  logic        peak_upd,
    input  logic [7:0]  peak_val,
    input  logic [8:0]  cnt_inc,
    output logic        irq,
    output logic        tx_soft_rst,
    output logic [15:0] xif_ctrl,
    output logic [15:0] tx_cfg,
    output logic [15:0] rx_cfg,
    output logic [7:0]  tx_thresh,
    output logic [15:0] rng_seed,
    output logic        tx_fifo_en,
    output logic [15:0] tx_fifo_bytes,
    output logic        rx_fifo_en,
    output logic [15:0] rx_fifo_bytes,
    output logic [47:0] station_addr,
    output logic [63:0] hash_tab
);
    reg_sel_t       sel;
    logic           wr_hit;
    logic [8:0]     txf_q, rxf_q;
    logic [DW-1:0]  sta_w  [NADDR];
    logic [DW-1:0]  hash_w [NHASH];
    logic [DW-1:0]  cnt_val [NCNT];
    logic [DW-1:0]  stat, mask;
    logic [PKW-1:0] peak;
    logic [DW-1:0]  rd_mux;

    assign sel    = decode(reg_addr);
    assign wr_hit = reg_wr;

    emac_evt_unit u_evt (
        .clk        (clk),
        .rst        (rst),
        .ev_set     (ev_status),
        .stat_rd    (reg_rd && sel.kind == RK_STAT),
        .mask_wr    (wr_hit && sel.kind == RK_MASK),
        .mask_wdata (reg_wdata),
        .peak_upd   (peak_upd),
        .peak_val   (peak_val),
        .peak_rd    (reg_rd && sel.kind == RK_PEAK),
        .stat       (stat),
        .mask       (mask),
        .peak       (peak),
        .irq        (irq)
    );

    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        localparam int W = cnt_width(i);
        logic [W-1:0] cq;
        emac_sat_ctr #(.W(W)) u_ctr (
            .clk    (clk),
            .rst    (rst),
            .inc    (cnt_inc[i]),
            .wr_en  (wr_hit && sel.kind == RK_CNT && sel.idx == 4'(i)),
            .wr_val (reg_wdata[W-1:0]),
            .cnt    (cq)
        );
        assign cnt_val[i] = DW'(cq);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xif_ctrl <= '0; tx_cfg <= '0; rx_cfg <= '0; tx_thresh <= '0;
            rng_seed <= '0; txf_q <= '0; rxf_q <= '0; tx_soft_rst <= 1'b0;
            for (int i = 0; i < NADDR; i++) sta_w[i]  <= '0;
            for (int i = 0; i < NHASH; i++) hash_w[i] <= '0;
        end else begin
            tx_soft_rst <= wr_hit && sel.kind == RK_TXRST && reg_wdata[0];
            if (wr_hit) begin
                case (sel.kind)
                    RK_XIF:   xif_ctrl  <= reg_wdata;
                    RK_TXF:   txf_q     <= reg_wdata[8:0];
                    RK_RXF:   rxf_q     <= reg_wdata[8:0];
                    RK_TXTH:  tx_thresh <= reg_wdata[7:0];
                    RK_TXCFG: tx_cfg    <= reg_wdata;
                    RK_RXCFG: rx_cfg    <= reg_wdata;
                    RK_SEED:  rng_seed  <= reg_wdata;
                    RK_STA:   sta_w[sel.idx[1:0]]  <= reg_wdata;
                    RK_HASH:  hash_w[sel.idx[1:0]] <= reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    for (genvar g = 0; g < NADDR; g++) begin : g_sta
        assign station_addr[16*g +: 16] = sta_w[g];
    end
    for (genvar g = 0; g < NHASH; g++) begin : g_hash
        assign hash_tab[16*g +: 16] = hash_w[g];
    end

    assign tx_fifo_en    = txf_q[0];
    assign rx_fifo_en    = rxf_q[0];
    assign tx_fifo_bytes = fifo_bytes(txf_q[8:1]);
    assign rx_fifo_bytes = fifo_bytes(rxf_q[8:1]);

    always_comb begin
        case (sel.kind)
            RK_XIF:   rd_mux = xif_ctrl;
            RK_TXF:   rd_mux = {7'd0, txf_q};
            RK_RXF:   rd_mux = {7'd0, rxf_q};
            RK_TXTH:  rd_mux = {8'd0, tx_thresh};
            RK_ID:    rd_mux = CHIP_ID;
            RK_STAT:  rd_mux = stat;
            RK_MASK:  rd_mux = mask;
            RK_TXRST: rd_mux = {15'd0, tx_soft_rst};
            RK_TXCFG: rd_mux = tx_cfg;
            RK_PEAK:  rd_mux = {8'd0, peak};
            RK_CNT:   rd_mux = cnt_val[sel.idx];
            RK_SEED:  rd_mux = rng_seed;
            RK_RXCFG: rd_mux = rx_cfg;
            RK_STA:   rd_mux = sta_w[sel.idx[1:0]];
            RK_HASH:  rd_mux = hash_w[sel.idx[1:0]];
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    assert_txrst_single_R10: assert property (@(posedge clk) disable iff (rst)
        tx_soft_rst |=> !tx_soft_rst);
    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && sel.kind == RK_NONE) |=> reg_rdata == '0);
    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> $stable(reg_rdata));
    assert_irq_masked_R4: assert property (@(posedge clk) disable iff (rst)
        (mask == '1) |-> !irq);
endmodule

// File: tb/sim_emac_csr_block.sv
`timescale 1ns/1ps
module sim_emac_csr_block;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_rdata;
    logic [15:0] ev_status = '0;
    logic        peak_upd = 1'b0;
    logic [7:0]  peak_val = '0;
    logic [8:0]  cnt_inc = '0;
    logic        irq, tx_soft_rst, tx_fifo_en, rx_fifo_en;
    logic [15:0] xif_ctrl, tx_cfg, rx_cfg, rng_seed, tx_fifo_bytes, rx_fifo_bytes;
    logic [7:0]  tx_thresh;
    logic [47:0] station_addr;
    logic [63:0] hash_tab;

    int n_vec = 0, n_bad = 0;

    typedef struct { logic [15:0] exp; logic [11:0] addr; string req; } sb_item_t;
    sb_item_t sb_q[$];
    logic rd_seen = 1'b0;

    always #10 clk = ~clk;

    emac_csr_block u0 (.*);

    task automatic report_done();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(posedge clk) rd_seen <= reg_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb_q.size() == 0) begin
                n_vec++; n_bad++;
                $display("FAIL R2: unexpected read data actual %0h expected none", reg_rdata);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                n_vec++;
                if (reg_rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: read %0h actual %0h expected %0h",
                             it.req, it.addr, reg_rdata, it.exp);
                end
            end
        end
    end

    task automatic bus_wr(input logic [11:0] a, input logic [15:0] d, input logic [8:0] inc = '0);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1; cnt_inc = inc;
        @(negedge clk);
        reg_wr = 1'b0; cnt_inc = '0;
    endtask

    task automatic bus_rd(input logic [11:0] a, input logic [15:0] e, input string req,
                          input logic [15:0] ev = '0);
        sb_item_t it;
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1; ev_status = ev;
        it.exp = e; it.addr = a; it.req = req;
        sb_q.push_back(it);
        @(negedge clk);
        reg_rd = 1'b0; ev_status = '0;
    endtask

    task automatic events(input logic [15:0] st, input logic [8:0] inc,
                          input logic pu, input logic [7:0] pv);
        @(negedge clk);
        ev_status = st; cnt_inc = inc; peak_upd = pu; peak_val = pv;
        @(negedge clk);
        ev_status = '0; cnt_inc = '0; peak_upd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        report_done();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(reg_rdata, 0, "R1"); chk(irq, 0, "R1"); chk(tx_soft_rst, 0, "R1");
        bus_rd(12'h210, 16'hFFFF, "R1");
        bus_rd(12'h200, 16'h0000, "R1");
        bus_rd(12'h500, 16'h0000, "R1");
        // R11 plain registers
        bus_wr(12'h000, 16'hA5C3);
        bus_rd(12'h000, 16'hA5C3, "R11");
        chk(xif_ctrl, 16'hA5C3, "R11");
        bus_wr(12'h110, 16'h1234);
        bus_rd(12'h110, 16'h0034, "R11");
        chk(tx_thresh, 8'h34, "R11");
        bus_wr(12'h430, 16'h0F0F); bus_wr(12'h630, 16'hF0F0); bus_wr(12'h540, 16'h1357);
        chk({tx_cfg, rx_cfg, rng_seed}, {16'h0F0F, 16'hF0F0, 16'h1357}, "R11");
        bus_rd(12'h540, 16'h1357, "R11");
        bus_wr(12'h170, 16'hFFFF);
        bus_rd(12'h170, 16'h000C, "R11");
        // R2 unmapped
        bus_wr(12'h7F0, 16'hBEEF);
        bus_rd(12'h7F0, 16'h0000, "R2");
        bus_rd(12'h180, 16'h0000, "R2");
        chk(xif_ctrl, 16'hA5C3, "R2");
        // R6 FIFO controls
        bus_wr(12'h100, 16'h0007);
        chk({tx_fifo_en, tx_fifo_bytes}, {1'b1, 16'd512}, "R6");
        bus_rd(12'h100, 16'h0007, "R6");
        bus_wr(12'h120, 16'h01FE);
        chk({rx_fifo_en, rx_fifo_bytes}, {1'b0, 16'd32768}, "R6");
        bus_wr(12'h100, 16'hFE01);
        chk({tx_fifo_en, tx_fifo_bytes}, {1'b1, 16'd128}, "R6");
        bus_rd(12'h100, 16'h0001, "R6");
        // R3 / R4 status and interrupt
        events(16'h0005, '0, 1'b0, '0);
        chk(irq, 0, "R4");
        bus_wr(12'h210, 16'hFFFB);
        chk(irq, 1, "R4");
        bus_rd(12'h200, 16'h0005, "R3");
        chk(irq, 0, "R3");
        bus_rd(12'h200, 16'h0000, "R3");
        bus_wr(12'h200, 16'hFFFF);
        bus_rd(12'h200, 16'h0000, "R11");
        events(16'h0002, '0, 1'b0, '0);
        bus_rd(12'h200, 16'h0002, "R3", 16'h0100);
        bus_rd(12'h200, 16'h0100, "R3");
        // R5 peak attempts
        events('0, '0, 1'b1, 8'd7);
        events('0, '0, 1'b1, 8'd3);
        bus_rd(12'h4E0, 16'h0007, "R5");
        bus_rd(12'h4E0, 16'h0000, "R5");
        bus_wr(12'h4E0, 16'h0055);
        bus_rd(12'h4E0, 16'h0000, "R5");
        // R7 counters
        repeat (3) events('0, 9'h001, 1'b0, '0);
        bus_rd(12'h500, 16'h0003, "R7");
        events('0, 9'h022, 1'b0, '0);
        bus_rd(12'h6A0, 16'h0001, "R7");
        bus_rd(12'h510, 16'h0001, "R7");
        bus_wr(12'h6C0, 16'h00FE);
        repeat (2) events('0, 9'h080, 1'b0, '0);
        bus_rd(12'h6C0, 16'h00FF, "R7");
        bus_wr(12'h520, 16'hFFFF);
        events('0, 9'h004, 1'b0, '0);
        bus_rd(12'h520, 16'hFFFF, "R7");
        // R8 counter writes
        bus_wr(12'h6B0, 16'h1234);
        bus_rd(12'h6B0, 16'h0034, "R8");
        bus_wr(12'h500, 16'h0010, 9'h001);
        bus_rd(12'h500, 16'h0010, "R8");
        // R9 address and hash
        bus_wr(12'h680, 16'h1111); bus_wr(12'h670, 16'h2222); bus_wr(12'h660, 16'h3333);
        chk(station_addr, 48'h3333_2222_1111, "R9");
        bus_rd(12'h660, 16'h3333, "R9");
        bus_wr(12'h700, 16'hAAAA); bus_wr(12'h730, 16'h5555);
        chk(hash_tab, 64'h5555_0000_0000_AAAA, "R9");
        bus_rd(12'h730, 16'h5555, "R9");
        // R10 transmit soft reset
        @(negedge clk);
        reg_addr = 12'h420; reg_wdata = 16'h0001; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        chk(tx_soft_rst, 1, "R10");
        @(negedge clk);
        chk(tx_soft_rst, 0, "R10");
        bus_rd(12'h420, 16'h0000, "R10");
        @(negedge clk);
        reg_addr = 12'h420; reg_wdata = 16'h0000; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        chk(tx_soft_rst, 0, "R10");
        repeat (2) @(negedge clk);
        chk(sb_q.size(), 0, "R2");
        report_done();
    end
endmodule